// File: doc/BRIEF.md
# TDM Timeslot Audio Translator

This block connects a single 16-bit timeslot of a time-division-multiplexed serial frame to a separate four-wire serial audio port, in both directions. On the TDM side it sees a bit strobe, a frame marker, two incoming data lines (endpoints A and B) and two outgoing data lines (also A and B). On the audio side it drives a bit clock, a frame sync and a serial data output, and it reads a serial data input. Everything runs on one system clock. The bit rate on each side is set by a strobe input that comes from outside the block.

In the receive direction the block picks up one timeslot from the chosen incoming endpoint. In the next TDM frame it sends that word out on the audio port, most significant bit first. In the transmit direction it collects one 16-bit word from the audio port during each audio frame. It places that word into the chosen timeslot of the next TDM frame, on the chosen outgoing endpoint.

A 13-bit configuration word sets the following:
- for each direction: the timeslot, the endpoint and an enable;
- a bypass mode that connects the TDM clock, marker and data straight to the audio port.

A master enable gates all of this. The configuration may only be changed while the master enable is low. Bypass mode is only meaningful when each TDM frame holds exactly one slot. The audio bit rate must be high enough that a 16-bit audio transfer finishes within N−1 TDM slot times, where N is the number of slots per frame.

Top module: `tdm_audio_bridge`

## Requirements
- R1: The configuration word is decoded as follows: bit 0 transmit enable; bit 1 transmit endpoint (0 = A, 1 = B); bit 2 receive enable; bit 3 receive endpoint (0 = A, 1 = B); bits 7:4 transmit slot; bits 11:8 receive slot; bit 12 bypass mode.
- R2: TDM bit position p counts strobes from the strobe that carries the frame marker (p = 0), and slot k covers positions 16k to 16k+15, MSB first. The receive slot's 16 bits, sampled from the selected input line at their strobes, appear on the audio data output during the audio frame that starts in the following TDM frame.
- R3: An audio frame starts at the first audio strobe at or after the TDM frame marker strobe. The audio clock output is high in the cycle after each audio strobe, and in that cycle the data output is valid. The frame sync output is high only together with the first bit, once per TDM frame. All three audio outputs are low after reset.
- R4: The 16 audio input bits, sampled at the 16 audio strobes of an audio frame (MSB first), are sent in the transmit slot of the next TDM frame on the selected output line. Each bit is driven from the cycle after its TDM strobe until the next strobe.
- R5: Every other slot, and the unselected output line, carries 0.
- R6: With the receive enable at 0, the audio output words are zero. With the transmit enable at 0, both TDM output lines stay at 0.
- R7: With the master enable at 0, zero words are sent in both directions, and any word held from earlier is discarded.
- R8: In bypass mode with the master enable at 1, the following pass through combinationally: the TDM strobe to the audio clock output, the TDM frame marker to the audio frame sync output, the selected TDM input line to the audio data output (gated by the receive enable), and the audio data input to the selected TDM output line (gated by the transmit enable).
- R9: Every slot from 0 up to NUM_SLOTS−1 can be chosen in either direction, including the last slot of a full-length frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable |
| cfg | input | 13 | Configuration word (R1 layout) |
| tdm_bit_en | input | 1 | TDM bit strobe |
| tdm_fs | input | 1 | TDM frame marker, valid with the strobe of bit 0 |
| tdm_in_a | input | 1 | TDM incoming data, endpoint A |
| tdm_in_b | input | 1 | TDM incoming data, endpoint B |
| tdm_out_a | output | 1 | TDM outgoing data, endpoint A |
| tdm_out_b | output | 1 | TDM outgoing data, endpoint B |
| aud_bit_en | input | 1 | Audio bit strobe |
| aud_sdi | input | 1 | Audio serial data in |
| aud_clk_o | output | 1 | Audio bit clock out |
| aud_fs_o | output | 1 | Audio frame sync out |
| aud_sdo | output | 1 | Audio serial data out |

## Verification
The bench uses the default parameters: 16-bit words and NUM_SLOTS = 16. It drives TDM frames of two lengths. Four-slot frames let many configurations run quickly, and every slot of such a frame is used as a receive or transmit slot. Full 16-slot frames bring in slot 15 and the wrap of the position counter at the end of the frame. The bench keeps the audio strobe at twice the TDM strobe rate, so each audio transfer ends well inside the N−1 slot budget. It also checks bypass mode combinationally with random line values.

// File: rtl/tab_pkg.sv
package tab_pkg;

    localparam int SEL_W = 4;
    localparam int CFG_W = 5 + 2 * SEL_W;

    // Packed order matches the configuration word, MSB first.
    typedef struct packed {
        logic             bypass;
        logic [SEL_W-1:0] rx_slot;
        logic [SEL_W-1:0] tx_slot;
        logic             rx_src_b;
        logic             rx_en;
        logic             tx_dst_b;
        logic             tx_en;
    } cfg_t;

    typedef struct packed {
        logic             tx_on;
        logic             rx_on;
        logic             bypass_on;
        logic             tx_dst_b;
        logic             rx_src_b;
        logic [SEL_W-1:0] tx_slot;
        logic [SEL_W-1:0] rx_slot;
    } ctl_t;

endpackage

// File: rtl/tab_cfg_decode.sv
module tab_cfg_decode
    import tab_pkg::*;
(
    input  logic             enable_i,
    input  logic [CFG_W-1:0] cfg_i,
    output ctl_t             ctl_o
);

    cfg_t fields;

    always_comb begin
        fields          = cfg_t'(cfg_i);
        ctl_o.tx_on     = enable_i & fields.tx_en;
        ctl_o.rx_on     = enable_i & fields.rx_en;
        ctl_o.bypass_on = enable_i & fields.bypass;
        ctl_o.tx_dst_b  = fields.tx_dst_b;
        ctl_o.rx_src_b  = fields.rx_src_b;
        ctl_o.tx_slot   = fields.tx_slot;
        ctl_o.rx_slot   = fields.rx_slot;
    end

endmodule

// File: rtl/tab_slot_engine.sv
module tab_slot_engine
    import tab_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_SLOTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              fs_i,
    input  logic              rx_bit_i,
    input  logic              rx_on_i,
    input  logic              tx_on_i,
    input  logic [SEL_W-1:0]  rx_slot_i,
    input  logic [SEL_W-1:0]  tx_slot_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              tx_bit_o
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam int POS_W = $clog2(NUM_SLOTS * WORD_W);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [WORD_W-2:0] rx_sh;
        logic [WORD_W-1:0] rx_word;
        logic [WORD_W-1:0] tx_frame;
        logic              tx_bit;
    } st_t;

    st_t state_d, state_q;

    logic [POS_W-1:0]       pos_next;
    logic [SEL_W-1:0]       slot_idx;
    logic [BIT_W-1:0]       bit_idx;
    logic [BIT_W-1:0]       msb_idx;
    logic [WORD_W-1:0]      frame_word;

    always_comb begin
        state_d    = state_q;
        pos_next   = fs_i ? '0 : state_q.pos + POS_W'(1);
        slot_idx   = SEL_W'(pos_next[POS_W-1:BIT_W]);
        bit_idx    = pos_next[BIT_W-1:0];
        msb_idx    = BIT_W'(WORD_W - 1) - bit_idx;
        frame_word = fs_i ? tx_word_i : state_q.tx_frame;

        if (bit_en_i) begin
            state_d.pos      = pos_next;
            state_d.tx_frame = frame_word;
            if (slot_idx == tx_slot_i) begin
                state_d.tx_bit = frame_word[msb_idx];
            end else begin
                state_d.tx_bit = 1'b0;
            end
            if (slot_idx == rx_slot_i) begin
                state_d.rx_sh = {state_q.rx_sh[WORD_W-3:0], rx_bit_i};
                if (bit_idx == BIT_W'(WORD_W - 1)) begin
                    state_d.rx_word = {state_q.rx_sh, rx_bit_i};
                end
            end
        end

        if (!rx_on_i) begin
            state_d.rx_sh   = '0;
            state_d.rx_word = '0;
        end
        if (!tx_on_i) begin
            state_d.tx_frame = '0;
            state_d.tx_bit   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_word_o = state_q.rx_word;
    assign tx_bit_o  = state_q.tx_bit;

    assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && fs_i) |=> (state_q.pos == '0))
        else $error("frame marker did not restart the bit position");

    assert_rx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on_i |=> (rx_word_o == '0))
        else $error("receive word kept while receive path off");

    assert_tx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on_i |=> !tx_bit_o)
        else $error("TDM output active while transmit path off");

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en_i && tx_on_i) |=> $stable(tx_bit_o))
        else $error("TDM output bit changed between strobes");

endmodule

// File: rtl/tab_audio_port.sv
module tab_audio_port #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              start_req_i,
    input  logic              out_on_i,
    input  logic              in_on_i,
    input  logic [WORD_W-1:0] out_word_i,
    input  logic              sdi_i,
    output logic [WORD_W-1:0] in_word_o,
    output logic              clk_o,
    output logic              fs_o,
    output logic              sdo_o
);

    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              pend;
        logic              busy;
        logic [BIT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh_out;
        logic [WORD_W-2:0] sh_in;
        logic [WORD_W-1:0] word_in;
        logic              aclk;
        logic              afs;
        logic              sdo;
    } st_t;

    st_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.aclk = strobe_i;
        state_d.afs  = 1'b0;
        if (start_req_i) begin
            state_d.pend = 1'b1;
        end

        if (strobe_i) begin
            if (!state_q.busy && (state_q.pend || start_req_i)) begin
                state_d.pend   = 1'b0;
                state_d.busy   = 1'b1;
                state_d.cnt    = '0;
                state_d.afs    = 1'b1;
                state_d.sdo    = out_word_i[WORD_W-1];
                state_d.sh_out = {out_word_i[WORD_W-2:0], 1'b0};
                state_d.sh_in  = {{(WORD_W-2){1'b0}}, sdi_i};
            end else if (state_q.busy) begin
                state_d.cnt    = state_q.cnt + BIT_W'(1);
                state_d.sdo    = state_q.sh_out[WORD_W-1];
                state_d.sh_out = {state_q.sh_out[WORD_W-2:0], 1'b0};
                state_d.sh_in  = {state_q.sh_in[WORD_W-3:0], sdi_i};
                if (state_q.cnt == BIT_W'(WORD_W - 2)) begin
                    state_d.busy    = 1'b0;
                    state_d.word_in = {state_q.sh_in, sdi_i};
                end
            end else begin
                state_d.sdo = 1'b0;
            end
        end

        if (!out_on_i) begin
            state_d.sh_out = '0;
            state_d.sdo    = 1'b0;
        end
        if (!in_on_i) begin
            state_d.sh_in   = '0;
            state_d.word_in = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_word_o = state_q.word_in;
    assign clk_o     = state_q.aclk;
    assign fs_o      = state_q.afs;
    assign sdo_o     = state_q.sdo;

    assert_fs_with_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> clk_o)
        else $error("audio frame sync without a clock pulse");

    assert_start_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.busy) |-> fs_o)
        else $error("audio frame began without frame sync");

    assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && out_on_i) |=> $stable(sdo_o))
        else $error("audio data changed between strobes");

endmodule

// File: rtl/tdm_audio_bridge.sv
module tdm_audio_bridge
    import tab_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] cfg,
    input  logic             tdm_bit_en,
    input  logic             tdm_fs,
    input  logic             tdm_in_a,
    input  logic             tdm_in_b,
    output logic             tdm_out_a,
    output logic             tdm_out_b,
    input  logic             aud_bit_en,
    input  logic             aud_sdi,
    output logic             aud_clk_o,
    output logic             aud_fs_o,
    output logic             aud_sdo
);

    ctl_t              ctl;
    logic              rx_line;
    logic              frame_start;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] tx_word;
    logic              eng_tx_bit;
    logic              port_clk;
    logic              port_fs;
    logic              port_sdo;
    logic              tx_line;

    tab_cfg_decode u_decode (
        .enable_i (enable),
        .cfg_i    (cfg),
        .ctl_o    (ctl)
    );

    assign rx_line     = ctl.rx_src_b ? tdm_in_b : tdm_in_a;
    assign frame_start = tdm_bit_en & tdm_fs;

    tab_slot_engine #(
        .WORD_W    (WORD_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en_i  (tdm_bit_en),
        .fs_i      (tdm_fs),
        .rx_bit_i  (rx_line),
        .rx_on_i   (ctl.rx_on),
        .tx_on_i   (ctl.tx_on),
        .rx_slot_i (ctl.rx_slot),
        .tx_slot_i (ctl.tx_slot),
        .tx_word_i (tx_word),
        .rx_word_o (rx_word),
        .tx_bit_o  (eng_tx_bit)
    );

    tab_audio_port #(
        .WORD_W (WORD_W)
    ) u_audio (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (aud_bit_en),
        .start_req_i (frame_start),
        .out_on_i    (ctl.rx_on),
        .in_on_i     (ctl.tx_on),
        .out_word_i  (rx_word),
        .sdi_i       (aud_sdi),
        .in_word_o   (tx_word),
        .clk_o       (port_clk),
        .fs_o        (port_fs),
        .sdo_o       (port_sdo)
    );

    always_comb begin
        if (ctl.bypass_on) begin
            aud_clk_o = tdm_bit_en;
            aud_fs_o  = tdm_fs;
            aud_sdo   = ctl.rx_on & rx_line;
            tx_line   = ctl.tx_on & aud_sdi;
        end else begin
            aud_clk_o = port_clk;
            aud_fs_o  = port_fs;
            aud_sdo   = port_sdo;
            tx_line   = eng_tx_bit;
        end
        tdm_out_a = tx_line & ~ctl.tx_dst_b;
        tdm_out_b = tx_line & ctl.tx_dst_b;
    end

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> (!aud_sdo && !tdm_out_a && !tdm_out_b))
        else $error("data left the block while disabled");

endmodule

// File: tb/tdm_audio_bridge_tb_top.sv
module tdm_audio_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [12:0] cfg;
    logic        tdm_bit_en, tdm_fs, tdm_in_a, tdm_in_b;
    logic        tdm_out_a, tdm_out_b;
    logic        aud_bit_en, aud_sdi;
    logic        aud_clk_o, aud_fs_o, aud_sdo;

    always #2 clk = ~clk;

    tdm_audio_bridge dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg        (cfg),
        .tdm_bit_en (tdm_bit_en),
        .tdm_fs     (tdm_fs),
        .tdm_in_a   (tdm_in_a),
        .tdm_in_b   (tdm_in_b),
        .tdm_out_a  (tdm_out_a),
        .tdm_out_b  (tdm_out_b),
        .aud_bit_en (aud_bit_en),
        .aud_sdi    (aud_sdi),
        .aud_clk_o  (aud_clk_o),
        .aud_fs_o   (aud_fs_o),
        .aud_sdo    (aud_sdo)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [15:0] rx_a [16];
    logic [15:0] rx_b [16];
    logic [15:0] got_a [16];
    logic [15:0] got_b [16];
    logic [15:0] got_aud;
    int          got_fs;
    logic [15:0] rx_hold = '0;
    logic [15:0] tx_hold = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] mk_cfg(input bit txen, input bit txb, input bit rxen,
                                           input bit rxb, input int txs, input int rxs,
                                           input bit byp);
        return {byp, 4'(rxs), 4'(txs), rxb, rxen, txb, txen};
    endfunction

    // One TDM frame of nslots slots; audio strobes at twice the TDM rate.
    task automatic run_frame(input int nslots, input logic [15:0] sdi_word);
        int aj = 16;
        got_fs  = 0;
        got_aud = '0;
        for (int s = 0; s < 16; s++) begin
            got_a[s] = '0;
            got_b[s] = '0;
        end
        for (int c = 0; c < nslots * 64; c++) begin
            int p = c / 4;
            tdm_bit_en = (c % 4 == 0);
            tdm_fs     = (c == 0);
            if (c % 4 == 0) begin
                tdm_in_a = rx_a[p / 16][15 - (p % 16)];
                tdm_in_b = rx_b[p / 16][15 - (p % 16)];
            end
            aud_bit_en = (c % 2 == 1);
            aud_sdi    = (c % 2 == 1 && c < 32) ? sdi_word[15 - (c - 1) / 2] : 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (c % 4 == 0) begin
                got_a[p / 16][15 - (p % 16)] = tdm_out_a;
                got_b[p / 16][15 - (p % 16)] = tdm_out_b;
            end
            if (aud_clk_o) begin
                if (aud_fs_o) begin
                    aj = 0;
                    got_fs++;
                end
                if (aj < 16) got_aud[15 - aj] = aud_sdo;
                aj++;
            end
        end
        tdm_bit_en = 1'b0;
        tdm_fs     = 1'b0;
        aud_bit_en = 1'b0;
        aud_sdi    = 1'b0;
    endtask

    // Model from the requirements: compare, then advance the held words.
    task automatic frame_and_check(input int nslots);
        logic [15:0] sdi_word = 16'($urandom);
        bit   rx_on = enable & cfg[2];
        bit   tx_on = enable & cfg[0];
        int   txs   = int'(cfg[7:4]);
        int   rxs   = int'(cfg[11:8]);
        string rq;
        for (int s = 0; s < 16; s++) begin
            rx_a[s] = 16'($urandom);
            rx_b[s] = 16'($urandom);
        end
        run_frame(nslots, sdi_word);
        check(got_fs == 1, "R3", "frame syncs per TDM frame", got_fs, 1);
        rq = !enable ? "R7" : (!cfg[2] ? "R6" : (nslots == 16 ? "R9" : "R1 R2"));
        check(got_aud == (rx_on ? rx_hold : 16'h0), rq, "audio word", got_aud,
              rx_on ? rx_hold : 16'h0);
        for (int s = 0; s < nslots; s++) begin
            logic [15:0] ea = (tx_on && !cfg[1] && s == txs) ? tx_hold : 16'h0;
            logic [15:0] eb = (tx_on && cfg[1] && s == txs) ? tx_hold : 16'h0;
            rq = !enable ? "R7" : (!cfg[0] ? "R6" : (s != txs ? "R5" :
                 (nslots == 16 ? "R9" : "R1 R4")));
            check(got_a[s] == ea, rq, $sformatf("line A slot %0d", s), got_a[s], ea);
            check(got_b[s] == eb, rq, $sformatf("line B slot %0d", s), got_b[s], eb);
        end
        rx_hold = rx_on ? (cfg[3] ? rx_b[rxs] : rx_a[rxs]) : 16'h0;
        tx_hold = tx_on ? sdi_word : 16'h0;
    endtask

    task automatic run_config(input logic [12:0] c, input int nslots, input int nframes);
        enable = 1'b0;
        cfg    = c;
        frame_and_check(nslots);
        enable = 1'b1;
        for (int f = 0; f < nframes; f++) frame_and_check(nslots);
        enable = 1'b0;
    endtask

    task automatic bypass_test(input logic [12:0] c);
        enable = 1'b0;
        cfg    = c;
        @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < 12; k++) begin
            logic ex_sdo, ex_a, ex_b;
            tdm_bit_en = 1'($urandom);
            tdm_fs     = 1'($urandom);
            tdm_in_a   = 1'($urandom);
            tdm_in_b   = 1'($urandom);
            aud_sdi    = 1'($urandom);
            #1;
            ex_sdo = c[2] & (c[3] ? tdm_in_b : tdm_in_a);
            ex_a   = c[0] & !c[1] & aud_sdi;
            ex_b   = c[0] & c[1] & aud_sdi;
            check(aud_clk_o == tdm_bit_en, "R8", "bypass clock", aud_clk_o, tdm_bit_en);
            check(aud_fs_o == tdm_fs, "R8", "bypass sync", aud_fs_o, tdm_fs);
            check(aud_sdo == ex_sdo, "R8", "bypass audio data", aud_sdo, ex_sdo);
            check({tdm_out_a, tdm_out_b} == {ex_a, ex_b}, "R8", "bypass TDM data",
                  {tdm_out_a, tdm_out_b}, {ex_a, ex_b});
            @(negedge clk);
        end
        tdm_bit_en = 1'b0;
        tdm_fs     = 1'b0;
        aud_sdi    = 1'b0;
        enable     = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        rst_n = 1'b0; enable = 1'b0; cfg = '0;
        tdm_bit_en = 1'b0; tdm_fs = 1'b0; tdm_in_a = 1'b0; tdm_in_b = 1'b0;
        aud_bit_en = 1'b0; aud_sdi = 1'b0;
        for (int s = 0; s < 16; s++) begin
            rx_a[s] = '0;
            rx_b[s] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({aud_clk_o, aud_fs_o, aud_sdo} == 3'b000, "R3", "audio outputs after reset",
              {aud_clk_o, aud_fs_o, aud_sdo}, 0);
        check({tdm_out_a, tdm_out_b} == 2'b00, "R7", "TDM outputs after reset",
              {tdm_out_a, tdm_out_b}, 0);

        run_config(mk_cfg(1, 0, 1, 0, 2, 1, 0), 4, 3);
        run_config(mk_cfg(1, 1, 1, 1, 0, 3, 0), 4, 3);
        run_config(mk_cfg(1, 0, 1, 1, 3, 3, 0), 4, 3);
        run_config(mk_cfg(0, 0, 1, 0, 1, 2, 0), 4, 3);
        run_config(mk_cfg(1, 1, 0, 0, 1, 2, 0), 4, 3);
        for (int r = 0; r < 3; r++) begin
            run_config(mk_cfg(1, 1'($urandom), 1, 1'($urandom),
                              int'($urandom % 4), int'($urandom % 4), 0), 4, 3);
        end
        run_config(mk_cfg(1, 1, 1, 0, 15, 15, 0), 16, 3);

        bypass_test(mk_cfg(1, 0, 1, 1, 0, 0, 1));
        bypass_test(mk_cfg(1, 1, 0, 0, 0, 0, 1));
        run_config(mk_cfg(1, 0, 1, 0, 0, 1, 0), 4, 2);

        done = 1'b1;
        finish_run();
    end

endmodule